// File: doc/BRIEF.md
# State-Dependent Transition Bus Coder

This block carries an M-bit data word across an N-bit physical bus (M < N) so that the wires only ever move between vectors along pre-approved transitions. The transmit half holds the vector currently on the wires as its state. For each qualified word it looks up the next vector in a table addressed by that state and the data value, and drives it. The word's value selects a successor by its position in ascending code order. Because the emitted vector depends on what was sent before, this is a transition code and not a fixed mapping from word to vector.

The receive half keeps the last accepted vector. It recovers the word by finding the position of the new vector among the table row of that stored vector. A vector that is not one of the first 2^M successors is reported as a coding error and is not accepted. Both tables are built at elaboration from one constant legality rule. The rule limits how many pins may toggle in one step, and it forbids two neighbouring pins from rising together or falling together. Every vector is in the allowed set. Holding a vector unchanged is itself a legal step. With the default N = 5 and MAX_TOG = 2, every vector has at least six legal successors, which is more than the 2^M = 4 that the default M = 2 needs.

Top module: `bus_codec`

## Requirements
- R1: During and right after reset, `bus_out` equals `RESET_VEC` (default 0), and `bus_valid_out`, `rx_data_valid`, `rx_err` and `rx_data` are all 0. The decoder's stored vector also starts at `RESET_VEC`.
- R2: When `tx_valid` is high at a clock edge, `bus_out` after that edge becomes the successor of index `tx_data` of the previous `bus_out`. Successors are counted from 0 in ascending numeric order of the legal next vectors. `bus_valid_out` after the edge equals `tx_valid` before it.
- R3: When `tx_valid` is low at an edge, `bus_out` keeps its value and `bus_valid_out` becomes 0.
- R4: A step from vector a to vector b is legal only when both of these hold:
  - at most `MAX_TOG` (default 2) bits differ between a and b;
  - no pair of neighbouring bits i and i+1 both go 0 to 1, and no such pair both go 1 to 0.

  A step from a vector to itself is legal.
- R5: When `rx_valid` is high and `rx_bus` is the successor of index r < 2^M of the stored vector, then after that edge `rx_data` = r and `rx_data_valid` = 1. The stored vector becomes `rx_bus`.
- R6: When `rx_valid` is high and `rx_bus` is not among the first 2^M successors of the stored vector, then after that edge `rx_err` = 1, `rx_data_valid` = 0 and `rx_data` = 0. The stored vector is unchanged.
- R7: When `rx_valid` is low, `rx_data_valid`, `rx_err` and `rx_data` are 0 after the edge, and the stored vector is unchanged.
- R8: With `bus_out` and `bus_valid_out` fed back to `rx_bus` and `rx_valid`, every word sent is recovered two edges later with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Qualifies `tx_data` this cycle |
| tx_data | input | M | Word to send |
| bus_out | output | N | Vector driven onto the physical bus |
| bus_valid_out | output | 1 | A new word was encoded onto `bus_out` at the last edge |
| rx_valid | input | 1 | Qualifies `rx_bus` this cycle |
| rx_bus | input | N | Vector received from the physical bus |
| rx_data | output | M | Recovered word |
| rx_data_valid | output | 1 | `rx_data` holds a word accepted at the last edge |
| rx_err | output | 1 | The last qualified vector was not a valid code step |

## Verification
An encoded vector appears on `bus_out` one edge after `tx_valid` is sampled. The decoder's verdict appears one edge after `rx_valid` is sampled, so in loopback a word returns two edges after it was sent. The bench drives its inputs on the falling edge. On the next falling edge it compares every output against a behavioural model that has been advanced by exactly one edge, so each result is checked in the cycle it is due. The model does its own search over legal successors to predict code vectors and ranks, and the error cases are produced by injecting vectors in place of the loopback.

// File: rtl/bcodec_pkg.sv
package bcodec_pkg;

    localparam int MAX_W = 16;

    // Legality of one bus step from a to b over the low w bits.
    function automatic bit step_ok(input logic [MAX_W-1:0] a,
                                   input logic [MAX_W-1:0] b,
                                   input int w,
                                   input int max_tog);
        int tog;
        bit ok;
        tog = 0;
        ok  = 1'b1;
        for (int i = 0; i < MAX_W; i++) begin
            if (i < w) begin
                if (a[i] != b[i]) tog++;
                if (i + 1 < w) begin
                    if (!a[i] && b[i] && !a[i+1] && b[i+1]) ok = 1'b0;
                    if (a[i] && !b[i] && a[i+1] && !b[i+1]) ok = 1'b0;
                end
            end
        end
        return ok && (tog <= max_tog);
    endfunction

endpackage

// File: rtl/succ_rom.sv
module succ_rom #(
    parameter int N       = 5,
    parameter int M       = 2,
    parameter int MAX_TOG = 2
) (
    input  logic [N-1:0]               row_sel,
    output logic [(1<<M)-1:0][N-1:0]   row
);
    localparam int S = 1 << N;
    localparam int K = 1 << M;

    // d-th legal successor of state s in ascending order.
    function automatic logic [N-1:0] nth_succ(input int s, input int d);
        int cnt;
        logic [N-1:0] r;
        cnt = 0;
        r   = N'(s);
        for (int v = 0; v < S; v++) begin
            if (bcodec_pkg::step_ok(16'(s), 16'(v), N, MAX_TOG)) begin
                if (cnt == d) r = N'(v);
                cnt++;
            end
        end
        return r;
    endfunction

    logic [S-1:0][K-1:0][N-1:0] tbl;

    for (genvar s = 0; s < S; s++) begin : g_state
        for (genvar d = 0; d < K; d++) begin : g_word
            localparam logic [N-1:0] ENT = nth_succ(s, d);
            assign tbl[s][d] = ENT;
        end
    end

    assign row = tbl[row_sel];

endmodule

// File: rtl/bus_enc.sv
module bus_enc #(
    parameter int N         = 5,
    parameter int M         = 2,
    parameter int MAX_TOG   = 2,
    parameter logic [N-1:0] RESET_VEC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [M-1:0] tx_data,
    output logic [N-1:0] bus_out,
    output logic         bus_valid_out
);
    localparam int K = 1 << M;

    typedef struct packed {
        logic [N-1:0] vec;
        logic         vld;
    } enc_st_t;

    enc_st_t st_q, st_d;
    logic [K-1:0][N-1:0] row;

    succ_rom #(.N(N), .M(M), .MAX_TOG(MAX_TOG)) u_rom (
        .row_sel (st_q.vec),
        .row     (row)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = tx_valid;
        if (tx_valid) st_d.vec = row[tx_data];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vec <= RESET_VEC;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_out       = st_q.vec;
    assign bus_valid_out = st_q.vld;

endmodule

// File: rtl/bus_dec.sv
module bus_dec #(
    parameter int N         = 5,
    parameter int M         = 2,
    parameter int MAX_TOG   = 2,
    parameter logic [N-1:0] RESET_VEC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [N-1:0] rx_bus,
    output logic [M-1:0] rx_data,
    output logic         rx_data_valid,
    output logic         rx_err
);
    localparam int K = 1 << M;

    typedef struct packed {
        logic [N-1:0] prev;
        logic [M-1:0] data;
        logic         dv;
        logic         err;
    } dec_st_t;

    dec_st_t st_q, st_d;
    logic [K-1:0][N-1:0] row;
    logic                hit;
    logic [M-1:0]        idx;

    succ_rom #(.N(N), .M(M), .MAX_TOG(MAX_TOG)) u_rom (
        .row_sel (st_q.prev),
        .row     (row)
    );

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < K; k++) begin
            if (!hit && row[k] == rx_bus) begin
                hit = 1'b1;
                idx = M'(k);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.data = '0;
        st_d.dv   = 1'b0;
        st_d.err  = 1'b0;
        if (rx_valid) begin
            if (hit) begin
                st_d.prev = rx_bus;
                st_d.data = idx;
                st_d.dv   = 1'b1;
            end else begin
                st_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= RESET_VEC;
            st_q.data <= '0;
            st_q.dv   <= 1'b0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data       = st_q.data;
    assign rx_data_valid = st_q.dv;
    assign rx_err        = st_q.err;

endmodule

// File: rtl/bus_codec.sv
module bus_codec #(
    parameter int N         = 5,
    parameter int M         = 2,
    parameter int MAX_TOG   = 2,
    parameter logic [N-1:0] RESET_VEC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [M-1:0] tx_data,
    output logic [N-1:0] bus_out,
    output logic         bus_valid_out,
    input  logic         rx_valid,
    input  logic [N-1:0] rx_bus,
    output logic [M-1:0] rx_data,
    output logic         rx_data_valid,
    output logic         rx_err
);

    bus_enc #(.N(N), .M(M), .MAX_TOG(MAX_TOG), .RESET_VEC(RESET_VEC)) u_enc (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .bus_out       (bus_out),
        .bus_valid_out (bus_valid_out)
    );

    bus_dec #(.N(N), .M(M), .MAX_TOG(MAX_TOG), .RESET_VEC(RESET_VEC)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_bus        (rx_bus),
        .rx_data       (rx_data),
        .rx_data_valid (rx_data_valid),
        .rx_err        (rx_err)
    );

endmodule

// File: rtl/bus_codec_chk.sv
module bus_codec_chk #(
    parameter int N       = 5,
    parameter int M       = 2,
    parameter int MAX_TOG = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_valid,
    input logic [N-1:0] bus_out,
    input logic         bus_valid_out,
    input logic         rx_valid,
    input logic [M-1:0] rx_data,
    input logic         rx_data_valid,
    input logic         rx_err
);

    // R2: the valid flag follows the qualifier by one edge
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_out == $past(tx_valid));

    // R3: the wire vector holds without a qualified word
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> $stable(bus_out));

    // R4: toggle budget on every step
    assert_toggle_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_out ^ $past(bus_out)) <= MAX_TOG);

    // R4: no neighbouring pair rises together
    assert_no_pair_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_out & ~$past(bus_out)) & ((bus_out & ~$past(bus_out)) >> 1)) == '0);

    // R4: no neighbouring pair falls together
    assert_no_pair_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~bus_out & $past(bus_out)) & ((~bus_out & $past(bus_out)) >> 1)) == '0);

    // R6: a verdict is either accepted or rejected, never both
    assert_verdict_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_data_valid && rx_err));

    // R7: no qualifier, no verdict
    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_data_valid && !rx_err && rx_data == '0));

endmodule

bind bus_codec bus_codec_chk #(.N(N), .M(M), .MAX_TOG(MAX_TOG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_valid      (tx_valid),
    .bus_out       (bus_out),
    .bus_valid_out (bus_valid_out),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_data_valid (rx_data_valid),
    .rx_err        (rx_err)
);

// File: tb/bus_codec_test.sv
module bus_codec_test;
    localparam int N = 5;
    localparam int M = 2;
    localparam int MAX_TOG = 2;
    localparam int K = 1 << M;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tx_valid;
    logic [M-1:0] tx_data;
    logic [N-1:0] bus_out;
    logic         bus_valid_out;
    logic         rx_valid;
    logic [N-1:0] rx_bus;
    logic [M-1:0] rx_data;
    logic         rx_data_valid;
    logic         rx_err;

    logic         inj_en, inj_v;
    logic [N-1:0] inj_bus;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // expected outputs
    int m_vec, m_vld, m_prev, m_rdata, m_rdv, m_rerr;

    always #10 clk = ~clk;

    assign rx_bus   = inj_en ? inj_bus : bus_out;
    assign rx_valid = inj_en ? inj_v   : bus_valid_out;

    bus_codec #(.N(N), .M(M), .MAX_TOG(MAX_TOG), .RESET_VEC('0)) uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .bus_out(bus_out), .bus_valid_out(bus_valid_out),
        .rx_valid(rx_valid), .rx_bus(rx_bus), .rx_data(rx_data),
        .rx_data_valid(rx_data_valid), .rx_err(rx_err)
    );

    function automatic bit legal(int a, int b);
        int flips = 0;
        for (int i = 0; i < N; i++) begin
            int pa = (a >> i) & 1, pb = (b >> i) & 1;
            if (pa != pb) flips++;
            if (i < N - 1) begin
                int qa = (a >> (i + 1)) & 1, qb = (b >> (i + 1)) & 1;
                if (pa == 0 && pb == 1 && qa == 0 && qb == 1) return 0;
                if (pa == 1 && pb == 0 && qa == 1 && qb == 0) return 0;
            end
        end
        return flips <= MAX_TOG;
    endfunction

    function automatic int succ(int s, int d);
        int c = 0;
        for (int v = 0; v < (1 << N); v++)
            if (legal(s, v)) begin
                if (c == d) return v;
                c++;
            end
        return -1;
    endfunction

    function automatic int rank_of(int s, int v);
        for (int d = 0; d < K; d++)
            if (succ(s, d) == v) return d;
        return -1;
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic compare_all(string rq);
        chk(int'(bus_out) == m_vec, rq, "bus_out", int'(bus_out), m_vec);
        chk(int'(bus_valid_out) == m_vld, rq, "bus_valid_out", int'(bus_valid_out), m_vld);
        chk(int'(rx_data) == m_rdata, rq, "rx_data", int'(rx_data), m_rdata);
        chk(int'(rx_data_valid) == m_rdv, rq, "rx_data_valid", int'(rx_data_valid), m_rdv);
        chk(int'(rx_err) == m_rerr, rq, "rx_err", int'(rx_err), m_rerr);
    endtask

    // One edge: drive after a falling edge, compare at the next falling edge.
    task automatic cyc(bit tv, int td, bit ie, bit iv, int ib, string rq);
        int seen_bus, seen_v, nvec, r;
        tx_valid = tv;
        tx_data  = M'(td);
        inj_en   = ie;
        inj_v    = iv;
        inj_bus  = N'(ib);
        seen_bus = ie ? ib : m_vec;
        seen_v   = ie ? int'(iv) : m_vld;
        nvec     = tv ? succ(m_vec, td) : m_vec;
        if (!legal(m_vec, nvec))
            chk(0, "R4", "model step legality", nvec, m_vec);
        m_vec = nvec;
        m_vld = tv;
        m_rdata = 0; m_rdv = 0; m_rerr = 0;
        if (seen_v != 0) begin
            r = rank_of(m_prev, seen_bus);
            if (r >= 0) begin
                m_rdata = r; m_rdv = 1; m_prev = seen_bus;
            end else begin
                m_rerr = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(rq);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tx_valid = 0; tx_data = '0;
        inj_en = 1'b0; inj_v = 1'b0; inj_bus = '0;
        m_vec = 0; m_vld = 0; m_prev = 0; m_rdata = 0; m_rdv = 0; m_rerr = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;

        // R3: idle edges hold the wire vector
        repeat (3) cyc(0, 0, 0, 0, 0, "R3");

        // R2 R8: loopback of every word from several states, with gaps
        for (int i = 0; i < 60; i++) begin
            cyc(1, (i * 7 + i / 5) % K, 0, 0, 0, "R2 R8");
            if (i % 9 == 4) cyc(0, 0, 0, 0, 0, "R3 R8");
        end
        // R2: repeated same word including self steps
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R7");

        // R6: too many toggles from the stored vector
        cyc(0, 0, 1, 1, m_prev ^ ((1 << N) - 1), "R6");
        // R6: legal step but ranked past the last code index
        cyc(0, 0, 1, 1, succ(m_prev, K), "R6");
        // R7: unqualified junk has no effect
        cyc(0, 0, 1, 0, m_prev ^ 3, "R7");
        // R5: injected valid code of each rank
        for (int d = K - 1; d >= 0; d--) cyc(0, 0, 1, 1, succ(m_prev, d), "R5");
        // R5: self step is accepted when it is a code word
        cyc(0, 0, 1, 1, m_prev, "R5");

        // resynchronise: decoder state now differs, so drive encoder and
        // decoder from a common point by reset
        rst_n = 1'b0; inj_en = 1'b0; tx_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        m_vec = 0; m_vld = 0; m_prev = 0; m_rdata = 0; m_rdv = 0; m_rerr = 0;
        compare_all("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) cyc(1, (i * 3 + 1) % K, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule